// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block is the engine behind a processor's memory block instructions. Software state arrives as a source pointer, a destination pointer, a byte count, an accumulator byte and the current flag bits. One pulse on `start` then runs either a byte copy from source to destination or a search that compares memory bytes against the accumulator. Both pointers step up or down as the direction input selects. Either operation runs as a single step or repeats until its end condition is met.

The sequencer drives a plain synchronous byte memory port. A read returns data in the cycle after the request. Every iteration takes four cycles in a fixed order: issue the read, wait for the data, write or compare, then test for the end. The updated pointers, count and flags stay visible on the outputs. A one-cycle `done` marks the end of the operation, and `busy` covers the whole run. Pointer width and count width are parameters, so a small configuration can sweep every count value including wrap-around.

Top module: `blk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are 0, and the pointer, count and flag outputs are all 0.
- R2: `start` is accepted only while `busy` is 0. Acceptance loads every operand input, and `busy` is 1 from the next cycle. A `start` or changed operand inputs while busy have no effect on the running operation or its results.
- R3: Each iteration reads the byte at the source pointer. In copy mode (`op_search`=0), the sequencer writes that byte to the destination pointer two cycles after the read request.
- R4: After each iteration the source pointer moves by +1 when `dir_dec`=0 and by -1 when `dir_dec`=1, wrapping modulo 2^AW. The destination pointer moves the same way in copy mode and is left unchanged in search mode.
- R5: Each iteration reduces the count by one, modulo 2^CW. A starting count of 0 therefore runs 2^CW iterations when the end condition depends on the count.
- R6: Flags use the bit layout [5]=S, [4]=Z, [3]=H, [2]=PV, [1]=N, [0]=C. A copy iteration clears H and N, sets PV to (new count != 0), and leaves S, Z and C unchanged.
- R7: A repeating copy iterates until the count reaches 0 and finishes with PV, H and N all 0.
- R8: A search iteration computes D = acc - byte (8 bits) and updates only the flags. It sets S=D[7], Z=(D==0), H=(acc[3:0] < byte[3:0]), N=1 and PV=(new count != 0), and leaves C unchanged.
- R9: A repeating search stops after the first iteration whose byte equals the accumulator, or after the iteration that brings the count to 0, whichever comes first.
- R10: With `repeat_en`=0 exactly one iteration runs, whatever the count.
- R11: An operation of n iterations raises `done` for exactly one cycle, 4n cycles after the accepting edge. `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_search | input | 1 | 0 = copy, 1 = compare-search |
| dir_dec | input | 1 | 0 = pointers increment, 1 = decrement |
| repeat_en | input | 1 | 1 = repeat until end condition, 0 = single step |
| src_i | input | AW | Initial source pointer |
| dst_i | input | AW | Initial destination pointer |
| cnt_i | input | CW | Initial byte count |
| acc_i | input | 8 | Accumulator value for search |
| flags_i | input | 6 | Initial flags {S,Z,H,PV,N,C} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| src_o | output | AW | Current source pointer |
| dst_o | output | AW | Current destination pointer |
| cnt_o | output | CW | Current count |
| flags_o | output | 6 | Current flags {S,Z,H,PV,N,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench runs with a 4-bit count, so a zero starting count must run all sixteen iterations. A design that tested before decrementing would stop at once and leave the count at zero. Pointers start near the top and bottom of the address space to expose a missing wrap. Overlapping copies catch a design that reads ahead or writes the wrong byte. Searches place the match on the first byte, on a middle byte, on the byte that also empties the count, and nowhere. A design with the wrong stop priority would run past the match or misreport PV. A sweep of every byte value against several accumulator values checks the half-borrow boundary, the sign and zero bits and the kept carry. A start pulse injected mid-run exposes a sequencer that reloads while busy.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;
   localparam int DW = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WAIT,
      ST_EXEC,
      ST_TEST
   } seq_state_t;

   typedef struct packed {
      logic s;
      logic z;
      logic h;
      logic pv;
      logic n;
      logic c;
   } seq_flags_t;
endpackage

// File: rtl/blkseq_ptr_step.sv
module blkseq_ptr_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr_i,
   input  logic          dec_i,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_comb begin
      if (dec_i) ptr_o = ptr_i - ONE;
      else       ptr_o = ptr_i + ONE;
   end
endmodule

// File: rtl/blkseq_cmp.sv
module blkseq_cmp
   import blkseq_pkg::*;
(
   input  logic [DW-1:0] acc_i,
   input  logic [DW-1:0] byte_i,
   output logic          sign_o,
   output logic          zero_o,
   output logic          hbor_o,
   output logic          match_o
);
   localparam int NIB = DW / 2;

   logic [DW-1:0] diff;

   always_comb begin
      diff    = acc_i - byte_i;
      sign_o  = diff[DW-1];
      zero_o  = (diff == '0);
      hbor_o  = (acc_i[NIB-1:0] < byte_i[NIB-1:0]);
      match_o = (acc_i == byte_i);
   end
endmodule

// File: rtl/blk_seq.sv
module blk_seq
   import blkseq_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_search,
   input  logic          dir_dec,
   input  logic          repeat_en,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [7:0]    acc_i,
   input  logic [5:0]    flags_i,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [CW-1:0] cnt_o,
   output logic [5:0]    flags_o,
   output logic          busy,
   output logic          done
);
   localparam int NPTR = 2;   // index 0 = source, 1 = destination
   localparam int PSRC = 0;
   localparam int PDST = 1;

   if (AW < 2) begin : g_bad_aw
      $error("blk_seq: AW must be at least 2");
   end
   if (CW < 1) begin : g_bad_cw
      $error("blk_seq: CW must be at least 1");
   end
   if (DW != 8) begin : g_bad_dw
      $error("blk_seq: data path is fixed at 8 bits");
   end

   seq_state_t            state;
   logic [NPTR-1:0][AW-1:0] ptr_q;
   logic [NPTR-1:0][AW-1:0] ptr_nxt;
   logic [CW-1:0]         cnt_q;
   logic [CW-1:0]         cnt_nxt;
   logic [DW-1:0]         acc_q;
   logic [DW-1:0]         byte_q;
   seq_flags_t            flg_q;
   logic                  srch_q;
   logic                  dec_q;
   logic                  rpt_q;
   logic                  stop_q;
   logic                  done_q;
   logic                  cmp_s, cmp_z, cmp_h, cmp_match;
   logic                  cnt_last;

   for (genvar g = 0; g < NPTR; g++) begin : g_step
      blkseq_ptr_step #(.AW(AW)) u_step (
         .ptr_i (ptr_q[g]),
         .dec_i (dec_q),
         .ptr_o (ptr_nxt[g])
      );
   end

   blkseq_cmp u_cmp (
      .acc_i   (acc_q),
      .byte_i  (byte_q),
      .sign_o  (cmp_s),
      .zero_o  (cmp_z),
      .hbor_o  (cmp_h),
      .match_o (cmp_match)
   );

   assign cnt_nxt  = cnt_q - CW'(1);
   assign cnt_last = (cnt_nxt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ptr_q  <= '0;
         cnt_q  <= '0;
         acc_q  <= '0;
         byte_q <= '0;
         flg_q  <= '0;
         srch_q <= 1'b0;
         dec_q  <= 1'b0;
         rpt_q  <= 1'b0;
         stop_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  ptr_q[PSRC] <= src_i;
                  ptr_q[PDST] <= dst_i;
                  cnt_q       <= cnt_i;
                  acc_q       <= acc_i;
                  flg_q       <= flags_i;
                  srch_q      <= op_search;
                  dec_q       <= dir_dec;
                  rpt_q       <= repeat_en;
                  state       <= ST_RD;
               end
            end
            ST_RD: state <= ST_WAIT;
            ST_WAIT: begin
               byte_q <= mem_rdata;
               state  <= ST_EXEC;
            end
            ST_EXEC: begin
               ptr_q[PSRC] <= ptr_nxt[PSRC];
               if (!srch_q) ptr_q[PDST] <= ptr_nxt[PDST];
               cnt_q    <= cnt_nxt;
               flg_q.pv <= !cnt_last;
               flg_q.n  <= srch_q;
               flg_q.h  <= srch_q & cmp_h;
               if (srch_q) begin
                  flg_q.s <= cmp_s;
                  flg_q.z <= cmp_z;
               end
               stop_q <= !rpt_q || cnt_last || (srch_q && cmp_match);
               state  <= ST_TEST;
            end
            ST_TEST: begin
               if (stop_q) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  state <= ST_RD;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = (state == ST_EXEC) && !srch_q;
      mem_req   = (state == ST_RD) || mem_we;
      mem_addr  = (state == ST_EXEC) ? ptr_q[PDST] : ptr_q[PSRC];
      mem_wdata = byte_q;
   end

   assign src_o   = ptr_q[PSRC];
   assign dst_o   = ptr_q[PDST];
   assign cnt_o   = cnt_q;
   assign flags_o = flg_q;
   assign busy    = (state != ST_IDLE);
   assign done    = done_q;

   // R3: a write always follows its read request by two cycles
   a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_req, 2) && !$past(mem_we, 2)));

   // R4: search leaves the destination pointer alone while running
   a_r4_search_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && srch_q) |=> $stable(dst_o));

   // R5: each execute cycle takes exactly one off the count
   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC) |=> (cnt_o == CW'($past(cnt_o) - CW'(1))));

   // R6: carry is never touched by a running operation
   a_r6_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(flags_o[0]));

   // R7: a finished repeating copy reports PV, H and N clear
   a_r7_copy_final_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !srch_q && rpt_q) |-> (flags_o[3:1] == 3'b000));

   // R8: a search iteration always leaves N set
   a_r8_search_n: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_TEST) && srch_q) |-> flags_o[1]);

   // R9: a repeating search stops on a match
   a_r9_stop_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_TEST) && srch_q && rpt_q && flags_o[4]) |=> !busy);

   // R11: done lasts one cycle and never overlaps busy
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/blk_seq_bench.sv
`timescale 1ns/1ps
module blk_seq_bench;
   localparam int AW = 8;
   localparam int CW = 4;
   localparam int MSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_search = 1'b0;
   logic          dir_dec = 1'b0;
   logic          repeat_en = 1'b0;
   logic [AW-1:0] src_i = '0;
   logic [AW-1:0] dst_i = '0;
   logic [CW-1:0] cnt_i = '0;
   logic [7:0]    acc_i = '0;
   logic [5:0]    flags_i = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;
   logic [AW-1:0] src_o, dst_o;
   logic [CW-1:0] cnt_o;
   logic [5:0]    flags_o;
   logic          busy, done;

   logic [7:0] mem [MSZ];
   logic [7:0] ref_mem [MSZ];

   int checks = 0;
   int failures = 0;
   int total_cyc = 0;

   always #5 clk = ~clk;

   blk_seq #(.AW(AW), .CW(CW)) u_blk_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_search(op_search),
      .dir_dec(dir_dec), .repeat_en(repeat_en), .src_i(src_i), .dst_i(dst_i),
      .cnt_i(cnt_i), .acc_i(acc_i), .flags_i(flags_i), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o),
      .flags_o(flags_o), .busy(busy), .done(done)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fill_mem(input int seed);
      for (int i = 0; i < MSZ; i++) begin
         mem[i]     = 8'((i * 37 + seed) ^ (i >> 2));
         ref_mem[i] = mem[i];
      end
   endtask

   task automatic put_byte(input int addr, input logic [7:0] v);
      mem[addr]     = v;
      ref_mem[addr] = v;
   endtask

   // Run one operation and compare against a model built from the requirements.
   task automatic run_op(input bit srch, input bit dec, input bit rpt,
                         input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input logic [CW-1:0] c, input logic [7:0] a,
                         input logic [5:0] f, input bit poke);
      logic [AW-1:0] rs, rd;
      logic [CW-1:0] rc;
      logic [5:0]    rf;
      logic [7:0]    b, diff;
      int            n, cyc, bad;
      bit            stop;
      rs = s; rd = d; rc = c; rf = f; n = 0; stop = 0;
      while (!stop) begin
         b = ref_mem[rs];
         if (!srch) ref_mem[rd] = b;
         rs = dec ? rs - 1'b1 : rs + 1'b1;
         if (!srch) rd = dec ? rd - 1'b1 : rd + 1'b1;
         rc = rc - 1'b1;
         n++;
         if (srch) begin
            diff  = a - b;
            rf[5] = diff[7];
            rf[4] = (diff == 8'h00);
            rf[3] = (a[3:0] < b[3:0]);
            rf[1] = 1'b1;
         end else begin
            rf[3] = 1'b0;
            rf[1] = 1'b0;
         end
         rf[2] = (rc != '0);
         stop = !rpt || (rc == '0) || (srch && a == b);
      end

      @(negedge clk);
      op_search = srch; dir_dec = dec; repeat_en = rpt;
      src_i = s; dst_i = d; cnt_i = c; acc_i = a; flags_i = f;
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) chk(busy == 1'b1, "R2 busy after start", busy, 1);
         if (poke && cyc == 3) begin
            start = 1'b1; src_i = s + 8'd9; dst_i = d + 8'd5; cnt_i = c + 4'd3;
            acc_i = ~a; op_search = ~srch; repeat_en = 1'b1;
         end
         if (poke && cyc == 4) start = 1'b0;
      end while (!done && cyc < 4 * (1 << CW) + 20);

      chk(cyc == 4 * n + 1, "R11 done timing", cyc, 4 * n + 1);
      chk(busy == 1'b0, "R11 busy low at done", busy, 0);
      chk(src_o == rs, "R4 source pointer", src_o, rs);
      chk(dst_o == rd, "R4 destination pointer", dst_o, rd);
      chk(cnt_o == rc, "R5 count", cnt_o, rc);
      if (srch) chk(flags_o == rf, rpt ? "R9 search flags" : "R8 search flags", flags_o, rf);
      else      chk(flags_o == rf, rpt ? "R7 copy flags" : "R6 copy flags", flags_o, rf);
      if (!srch) begin
         bad = 0;
         for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) bad++;
         chk(bad == 0, "R3 memory contents after copy", bad, 0);
      end
      if (!rpt) chk(n == 1, "R10 single iteration", n, 1);
      @(negedge clk);
      chk(done == 1'b0, "R11 done one cycle", done, 0);
      if (poke) begin
         @(negedge clk);
         chk(busy == 1'b0, "R2 start while busy ignored", busy, 0);
         op_search = srch; repeat_en = rpt;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         total_cyc++;
         if (total_cyc > 190000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", total_cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      fill_mem(3);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
      chk(mem_req == 0 && mem_we == 0, "R1 memory idle after reset", {mem_req, mem_we}, 0);
      chk(src_o == 0 && dst_o == 0 && cnt_o == 0, "R1 registers after reset",
          {src_o, dst_o, cnt_o}, 0);
      chk(flags_o == 0, "R1 flags after reset", flags_o, 0);

      // R6 R10: single copy steps, both directions, flags S,Z,C kept
      run_op(0, 0, 0, 8'h10, 8'h80, 4'd5, 8'h00, 6'b110001, 0);
      run_op(0, 1, 0, 8'h00, 8'hFF, 4'd1, 8'h00, 6'b001110, 0);
      run_op(0, 0, 0, 8'hFF, 8'h00, 4'd0, 8'h00, 6'b100100, 0);
      // R7: repeating copies, overlap, wrap, zero count = 16 iterations (R5)
      run_op(0, 0, 1, 8'h20, 8'h60, 4'd5, 8'h00, 6'b011111, 0);
      run_op(0, 1, 1, 8'h43, 8'h90, 4'd3, 8'h00, 6'b000000, 0);
      run_op(0, 0, 1, 8'h30, 8'h31, 4'd6, 8'h00, 6'b000001, 0);
      run_op(0, 1, 1, 8'h51, 8'h50, 4'd6, 8'h00, 6'b000001, 0);
      run_op(0, 0, 1, 8'hF8, 8'h04, 4'd0, 8'h00, 6'b101011, 0);
      run_op(0, 1, 1, 8'h05, 8'hFA, 4'd0, 8'h00, 6'b000000, 0);
      // R2: start pulse mid-run is ignored
      run_op(0, 0, 1, 8'h70, 8'hB0, 4'd4, 8'h00, 6'b000000, 1);

      // R8: sweep of every byte value against several accumulators
      for (int ai = 0; ai < 4; ai++) begin
         for (int bv = 0; bv < 256; bv++) begin
            logic [7:0] av;
            av = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h5A : (ai == 2) ? 8'h80 : 8'hFF;
            put_byte(8'h40, 8'(bv));
            run_op(1, bv[1], 0, 8'h40, 8'h11, 4'(bv + 1), av, {5'b0, bv[0]}, 0);
         end
      end

      // R9: repeating searches
      fill_mem(11);
      for (int i = 0; i < MSZ; i++) if (mem[i] == 8'hC3) put_byte(i, 8'h3C);
      put_byte(8'h20, 8'hC3);
      run_op(1, 0, 1, 8'h20, 8'h00, 4'd7, 8'hC3, 6'b000001, 0);   // first byte
      run_op(1, 0, 1, 8'h1C, 8'h00, 4'd9, 8'hC3, 6'b000000, 0);   // middle
      run_op(1, 0, 1, 8'h1D, 8'h00, 4'd4, 8'hC3, 6'b000001, 0);   // match on last
      run_op(1, 1, 1, 8'h25, 8'h00, 4'd3, 8'hC3, 6'b000000, 0);   // no match
      run_op(1, 1, 1, 8'h24, 8'h00, 4'd5, 8'hC3, 6'b000001, 0);   // match going down
      run_op(1, 0, 1, 8'h80, 8'h33, 4'd0, 8'hC3, 6'b000001, 0);   // 16 misses
      run_op(1, 0, 1, 8'hF9, 8'h33, 4'd12, 8'hC3, 6'b000000, 1);  // wrap, poke

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule